// File: doc/BRIEF.md
# Memory ECC Error Capture and Injection Register Block

This block sits beside the ECC datapath of a memory controller. Each cycle the datapath may present the result of a check on a read: the data word, the received check bits, the access address and flags for a corrected (single-bit) or uncorrectable (multi-bit) error. The block turns these into sticky status flags, freezes the first failing access into capture registers, and drives an interrupt. Single-bit errors first go through a counter. A flag is raised only when the counter reaches a programmable threshold.

Software reaches the block through a plain 32-bit register port. Writes take effect on the clock edge. Read data follows the address combinationally and reading has no side effects. The same register space holds injection masks. The write datapath routes its data and check bits through the block, and while injection is armed the masks are XORed onto them.

Top module: `mem_err_regs`

## Requirements
- R1: After reset every mapped register reads zero and `irq` is low.
- R2: A multi-bit event (`chk_valid` and `chk_mbe`) sets status bit 1 (offset 0x00) at the next clock edge. A single-bit event feeds the counter described in R7, and status bit 0 is set only through that counter.
- R3: Writing status (0x00) clears each bit written as 1 and leaves each bit written as 0. Writing 0xFFFFFFFF clears both flags. A flag that is being set in the same cycle as a clearing write stays set.
- R4: A capture occurs on an event that sets a status flag while both flags read zero. The capture loads data high (0x10) and data low (0x14) from `chk_data[63:32]` and `chk_data[31:0]`. While any flag is set, the capture registers do not change.
- R5: The same capture loads the address low (0x1C) from `chk_addr[31:0]` and the address high (0x20) from `chk_addr[63:32]`.
- R6: The captured check value (0x18) holds `chk_ecc[7:0]` with zero in the upper bits when `bus_narrow` is 0. It holds `chk_ecc[15:0]` when `bus_narrow` is 1.
- R7: Offset 0x0C holds the threshold in bits 23:16 and a read-only count in bits 7:0. Each counted single-bit event either increments the count or, when count+1 is at least the threshold, sets status bit 0 and returns the count to 0. A threshold of 0 or 1 therefore flags every single-bit event.
- R8: `irq` is high exactly while a status bit is set whose enable bit is also set at offset 0x04 (bit 0 single-bit, bit 1 multi-bit).
- R9: Offset 0x08 bit 0 suppresses single-bit events and bit 1 suppresses multi-bit events. A suppressed event changes no flag, no count and no capture. A value of zero lets all events through.
- R10: Inject masks are read/write: data high at 0x24, data low at 0x28, and control at 0x2C. The control register holds the check-bit mask in bits 7:0 and the arm bit in bit 8. While armed, `wr_data_out` = `wr_data_in` XOR the data masks and `wr_ecc_out` = `wr_ecc_in` XOR the check-bit mask. While disarmed, both pass through unchanged.
- R11: Unmapped offsets read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high together with reg_en |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| bus_narrow | input | 1 | 1 = 32-bit bus mode, keep 16 check bits |
| chk_valid | input | 1 | Check result valid this cycle |
| chk_sbe | input | 1 | Corrected single-bit error |
| chk_mbe | input | 1 | Uncorrectable multi-bit error |
| chk_data | input | 64 | Data word of the checked access |
| chk_ecc | input | 16 | Received check bits |
| chk_addr | input | 64 | Address of the checked access |
| wr_data_in | input | 64 | Write data from the datapath |
| wr_ecc_in | input | 8 | Write check bits from the datapath |
| wr_data_out | output | 64 | Write data after injection |
| wr_ecc_out | output | 8 | Write check bits after injection |
| irq | output | 1 | Error interrupt |

## Verification
Register writes and check events take effect at the clock edge that follows the cycle they are presented. Status, count, capture registers and `irq` are therefore all due one edge later, and `irq` is decoded from registered state without adding a cycle. The injection outputs and read data are combinational and are due in the same cycle. The bench drives inputs on the falling edge, removes them one falling edge later, and reads the registers after that. It compares each result with a reference model that the bench updates when it applies the stimulus.

// File: rtl/mer_pkg.sv
package mer_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam int CNT_W  = 8;

  localparam int FLAG_SB = 0;
  localparam int FLAG_MB = 1;

  localparam logic [REG_AW-1:0] OFF_STATUS   = 8'h00;
  localparam logic [REG_AW-1:0] OFF_INT_EN   = 8'h04;
  localparam logic [REG_AW-1:0] OFF_SUPPRESS = 8'h08;
  localparam logic [REG_AW-1:0] OFF_SB_CTL   = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_CAP_DHI  = 8'h10;
  localparam logic [REG_AW-1:0] OFF_CAP_DLO  = 8'h14;
  localparam logic [REG_AW-1:0] OFF_CAP_ECC  = 8'h18;
  localparam logic [REG_AW-1:0] OFF_CAP_ALO  = 8'h1C;
  localparam logic [REG_AW-1:0] OFF_CAP_AHI  = 8'h20;
  localparam logic [REG_AW-1:0] OFF_INJ_DHI  = 8'h24;
  localparam logic [REG_AW-1:0] OFF_INJ_DLO  = 8'h28;
  localparam logic [REG_AW-1:0] OFF_INJ_CTL  = 8'h2C;

  typedef logic [1:0] flag_pair_t;

  // True when the next counted event reaches the threshold.
  function automatic logic limit_reached(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] lim);
    return ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, lim};
  endfunction

  // Keeps 8 or 16 check bits depending on the bus mode.
  function automatic logic [15:0] keep_check(logic [15:0] raw, logic narrow);
    return narrow ? raw : {8'h00, raw[7:0]};
  endfunction
endpackage

// File: rtl/mer_detect.sv
module mer_detect
  import mer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_valid,
  input  logic             chk_sbe,
  input  logic             chk_mbe,
  input  flag_pair_t       suppress,
  input  logic [CNT_W-1:0] limit,
  input  logic             clr_en,
  input  flag_pair_t       clr_mask,
  output flag_pair_t       flags,
  output logic [CNT_W-1:0] sb_count,
  output flag_pair_t       set_ev,
  output logic             first_ev
);
  logic sb_seen, mb_seen, sb_hit;

  assign sb_seen  = chk_valid & chk_sbe & ~suppress[FLAG_SB];
  assign mb_seen  = chk_valid & chk_mbe & ~suppress[FLAG_MB];
  assign sb_hit   = sb_seen & limit_reached(sb_count, limit);
  assign set_ev   = {mb_seen, sb_hit};
  assign first_ev = (|set_ev) & ~(|flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_count <= '0;
    end else if (sb_seen) begin
      sb_count <= sb_hit ? '0 : sb_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~(clr_en ? clr_mask : 2'b00)) | set_ev;
    end
  end

  AST_MB_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_mbe && !suppress[FLAG_MB]) |=> flags[FLAG_MB]); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mask[FLAG_MB] && !(chk_valid && chk_mbe)) |=> !flags[FLAG_MB]); // R3
  AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_hit) |=> (sb_count == '0)); // R7
  AST_SUPPRESS_MB: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[FLAG_MB] && suppress[FLAG_MB]) |=> !flags[FLAG_MB]); // R9
endmodule

// File: rtl/mer_capture.sv
module mer_capture
  import mer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int ECC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              narrow,
  input  logic [DATA_W-1:0] data,
  input  logic [ECC_W-1:0]  ecc,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [ECC_W-1:0]  cap_ecc,
  output logic [ADDR_W-1:0] cap_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      cap_ecc  <= '0;
      cap_addr <= '0;
    end else if (load) begin
      cap_data <= data;
      cap_ecc  <= keep_check(ecc, narrow);
      cap_addr <= addr;
    end
  end

  AST_WIDE_ECC: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !narrow) |=> (cap_ecc[15:8] == 8'h00)); // R6
endmodule

// File: rtl/mer_inject.sv
module mer_inject #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input  logic              armed,
  input  logic [DATA_W-1:0] data_mask,
  input  logic [CHK_W-1:0]  chk_mask,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHK_W-1:0]  chk_in,
  output logic [DATA_W-1:0] data_out,
  output logic [CHK_W-1:0]  chk_out
);
  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_lane
      assign data_out[g] = data_in[g] ^ (armed & data_mask[g]);
    end
    for (g = 0; g < CHK_W; g++) begin : g_chk
      assign chk_out[g] = chk_in[g] ^ (armed & chk_mask[g]);
    end
  endgenerate

  always_comb begin
    if (!armed) begin
      AST_DISARMED_PASS: assert (data_out == data_in && chk_out == chk_in); // R10
    end
  end
endmodule

// File: rtl/mem_err_regs.sv
module mem_err_regs
  import mer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int ECC_W  = 16,
  parameter int CHK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              bus_narrow,
  input  logic              chk_valid,
  input  logic              chk_sbe,
  input  logic              chk_mbe,
  input  logic [DATA_W-1:0] chk_data,
  input  logic [ECC_W-1:0]  chk_ecc,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [DATA_W-1:0] wr_data_in,
  input  logic [CHK_W-1:0]  wr_ecc_in,
  output logic [DATA_W-1:0] wr_data_out,
  output logic [CHK_W-1:0]  wr_ecc_out,
  output logic              irq
);
  localparam int HALF_D = DATA_W / 2;
  localparam int HALF_A = ADDR_W / 2;
  localparam int INJ_CW = CHK_W + 1;

  flag_pair_t       int_en, suppress, flags, set_ev;
  logic [CNT_W-1:0] limit, sb_count;
  logic [HALF_D-1:0] inj_hi, inj_lo;
  logic [INJ_CW-1:0] inj_ctl;
  logic              first_ev, wr_any, clr_en;
  logic [DATA_W-1:0] cap_data;
  logic [ECC_W-1:0]  cap_ecc;
  logic [ADDR_W-1:0] cap_addr;

  assign wr_any = reg_en & reg_we;
  assign clr_en = wr_any & (reg_addr == OFF_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en   <= '0;
      suppress <= '0;
      limit    <= '0;
      inj_hi   <= '0;
      inj_lo   <= '0;
      inj_ctl  <= '0;
    end else if (wr_any) begin
      case (reg_addr)
        OFF_INT_EN:   int_en   <= reg_wdata[1:0];
        OFF_SUPPRESS: suppress <= reg_wdata[1:0];
        OFF_SB_CTL:   limit    <= reg_wdata[16 +: CNT_W];
        OFF_INJ_DHI:  inj_hi   <= reg_wdata[HALF_D-1:0];
        OFF_INJ_DLO:  inj_lo   <= reg_wdata[HALF_D-1:0];
        OFF_INJ_CTL:  inj_ctl  <= reg_wdata[INJ_CW-1:0];
        default: ;
      endcase
    end
  end

  mer_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_valid(chk_valid),
    .chk_sbe  (chk_sbe),
    .chk_mbe  (chk_mbe),
    .suppress (suppress),
    .limit    (limit),
    .clr_en   (clr_en),
    .clr_mask (reg_wdata[1:0]),
    .flags    (flags),
    .sb_count (sb_count),
    .set_ev   (set_ev),
    .first_ev (first_ev)
  );

  mer_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ECC_W(ECC_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (first_ev),
    .narrow  (bus_narrow),
    .data    (chk_data),
    .ecc     (chk_ecc),
    .addr    (chk_addr),
    .cap_data(cap_data),
    .cap_ecc (cap_ecc),
    .cap_addr(cap_addr)
  );

  mer_inject #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inject (
    .armed    (inj_ctl[CHK_W]),
    .data_mask({inj_hi, inj_lo}),
    .chk_mask (inj_ctl[CHK_W-1:0]),
    .data_in  (wr_data_in),
    .chk_in   (wr_ecc_in),
    .data_out (wr_data_out),
    .chk_out  (wr_ecc_out)
  );

  assign irq = |(flags & int_en);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_STATUS:   reg_rdata[1:0] = flags;
      OFF_INT_EN:   reg_rdata[1:0] = int_en;
      OFF_SUPPRESS: reg_rdata[1:0] = suppress;
      OFF_SB_CTL:   begin
        reg_rdata[16 +: CNT_W] = limit;
        reg_rdata[CNT_W-1:0]   = sb_count;
      end
      OFF_CAP_DHI:  reg_rdata[HALF_D-1:0] = cap_data[DATA_W-1:HALF_D];
      OFF_CAP_DLO:  reg_rdata[HALF_D-1:0] = cap_data[HALF_D-1:0];
      OFF_CAP_ECC:  reg_rdata[ECC_W-1:0]  = cap_ecc;
      OFF_CAP_ALO:  reg_rdata[HALF_A-1:0] = cap_addr[HALF_A-1:0];
      OFF_CAP_AHI:  reg_rdata[HALF_A-1:0] = cap_addr[ADDR_W-1:HALF_A];
      OFF_INJ_DHI:  reg_rdata[HALF_D-1:0] = inj_hi;
      OFF_INJ_DLO:  reg_rdata[HALF_D-1:0] = inj_lo;
      OFF_INJ_CTL:  reg_rdata[INJ_CW-1:0] = inj_ctl;
      default: ;
    endcase
  end

  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != 2'b00) |=> ($stable(cap_data) && $stable(cap_addr) && $stable(cap_ecc))); // R4
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 2'b00)); // R8
  AST_SB_ONLY_VIA_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[FLAG_SB] && !set_ev[FLAG_SB]) |=> !flags[FLAG_SB]); // R2
endmodule

// File: tb/tb_mem_err_regs.sv
module tb_mem_err_regs;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_n = 0;
  logic        reg_en = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        bus_narrow = 0, chk_valid = 0, chk_sbe = 0, chk_mbe = 0;
  logic [63:0] chk_data = 0, chk_addr = 0, wr_data_in = 0, wr_data_out;
  logic [15:0] chk_ecc = 0;
  logic [7:0]  wr_ecc_in = 0, wr_ecc_out;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0]  m_flags, m_en, m_sup;
  logic [7:0]  m_lim, m_cnt;
  logic [63:0] m_cdata, m_caddr;
  logic [15:0] m_cecc;

  mem_err_regs dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Reference for one check event; returns nothing, updates the model.
  task automatic ev(bit sb, bit mb, logic [63:0] d, logic [15:0] e, logic [63:0] a);
    bit s_cnt, m_set, s_set;
    @(negedge clk);
    chk_valid = 1; chk_sbe = sb; chk_mbe = mb; chk_data = d; chk_ecc = e; chk_addr = a;
    @(negedge clk);
    chk_valid = 0; chk_sbe = 0; chk_mbe = 0;
    s_cnt = sb && !m_sup[0];
    m_set = mb && !m_sup[1];
    s_set = 0;
    if (s_cnt) begin
      if (int'(m_cnt) + 1 >= int'(m_lim)) begin s_set = 1; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    if ((s_set || m_set) && m_flags == 2'b00) begin
      m_cdata = d; m_caddr = a;
      m_cecc = bus_narrow ? e : (e & 16'h00ff);
    end
    m_flags = m_flags | {m_set, s_set};
  endtask

  task automatic check_state(string req);
    logic [31:0] r;
    rd(8'h00, r); check({req, " status"}, r, {30'd0, m_flags});
    rd(8'h0C, r); check({req, " sbctl"}, r, {8'd0, m_lim, 8'd0, m_cnt});
    check({req, " irq"}, irq, |(m_flags & m_en));
    rd(8'h10, r); check({req, " cap dhi"}, r, m_cdata[63:32]);
    rd(8'h14, r); check({req, " cap dlo"}, r, m_cdata[31:0]);
    rd(8'h18, r); check({req, " cap ecc"}, r, {16'd0, m_cecc});
    rd(8'h1C, r); check({req, " cap alo"}, r, m_caddr[31:0]);
    rd(8'h20, r); check({req, " cap ahi"}, r, m_caddr[63:32]);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_0042));
    m_flags = 0; m_en = 0; m_sup = 0; m_lim = 0; m_cnt = 0;
    m_cdata = 0; m_caddr = 0; m_cecc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 8'h2C; a += 4) begin
      rd(a[7:0], r); check("R1 reset reg", r, 0);
    end
    check("R1 reset irq", irq, 0);

    // R2, R4, R5, R6 first multi-bit capture, wide bus
    wr(8'h04, 32'h3); m_en = 2'b11;
    ev(0, 1, 64'h1122_3344_5566_7788, 16'hABCD, 64'h0000_00F0_1234_5678);
    check_state("R2 R4 R5 R6 first mb");
    // R4 second event leaves capture frozen
    ev(0, 1, 64'hFFFF_0000_FFFF_0000, 16'h1111, 64'h9);
    check_state("R4 frozen");
    // R3 all-ones clear
    wr(8'h00, 32'hFFFF_FFFF); m_flags = 0;
    check_state("R3 clear all");

    // R6 narrow mode keeps 16 bits
    bus_narrow = 1;
    ev(0, 1, 64'h5, 16'hBEEF, 64'h7);
    check_state("R6 narrow");
    wr(8'h00, 32'h2); m_flags = 0;
    bus_narrow = 0;

    // R7 threshold 3: two events count, third flags
    wr(8'h0C, 32'h0003_0000); m_lim = 3;
    ev(1, 0, 64'hA, 16'h1, 64'hB); check_state("R7 count1");
    ev(1, 0, 64'hA, 16'h1, 64'hB); check_state("R7 count2");
    ev(1, 0, 64'hC, 16'h2, 64'hD); check_state("R7 limit hit");
    // R8 irq masked when enable cleared
    wr(8'h04, 32'h2); m_en = 2'b10; check_state("R8 masked");
    // R3 clearing only bit 1 keeps bit 0
    wr(8'h00, 32'h2); check_state("R3 partial clear");
    wr(8'h00, 32'h1); m_flags = 0;

    // R3 set wins over same-cycle clear
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = 8'h00; reg_wdata = 32'h3;
    chk_valid = 1; chk_mbe = 1; chk_data = 64'h77; chk_ecc = 16'h22; chk_addr = 64'h33;
    @(negedge clk);
    reg_en = 0; reg_we = 0; chk_valid = 0; chk_mbe = 0;
    m_flags = 2'b10; m_cdata = 64'h77; m_cecc = 16'h22; m_caddr = 64'h33;
    check_state("R3 set wins");
    wr(8'h00, 32'h3); m_flags = 0;

    // R9 suppression of both kinds
    wr(8'h08, 32'h3); m_sup = 2'b11;
    ev(1, 1, 64'h99, 16'h9, 64'h99); check_state("R9 suppressed");
    wr(8'h08, 32'h0); m_sup = 0;
    rd(8'h08, r); check("R9 readback", r, 0);

    // R10 injection
    wr(8'h24, 32'hDEAD_BEEF); wr(8'h28, 32'h0F0F_0F0F); wr(8'h2C, 32'h0000_00A5);
    rd(8'h24, r); check("R10 inj hi", r, 32'hDEAD_BEEF);
    rd(8'h28, r); check("R10 inj lo", r, 32'h0F0F_0F0F);
    rd(8'h2C, r); check("R10 inj ctl", r, 32'hA5);
    wr_data_in = 64'h0123_4567_89AB_CDEF; wr_ecc_in = 8'h3C; #1;
    check("R10 disarmed data", wr_data_out, wr_data_in);
    check("R10 disarmed ecc", wr_ecc_out, wr_ecc_in);
    wr(8'h2C, 32'h0000_01A5); #1;
    check("R10 armed data", wr_data_out, wr_data_in ^ 64'hDEAD_BEEF_0F0F_0F0F);
    check("R10 armed ecc", wr_ecc_out, wr_ecc_in ^ 8'hA5);

    // R11 unmapped offset
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, r); check("R11 unmapped read", r, 0);
    check_state("R11 no side effect");

    // R2 R3 R4 R7 R8 random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 10;
      if (op < 7) begin
        int f;
        f = $urandom % 4;
        ev(f[0], f[1], {$urandom, $urandom}, 16'($urandom), {$urandom, $urandom});
      end else if (op == 7) begin
        logic [1:0] mk;
        mk = 2'($urandom);
        wr(8'h00, {30'd0, mk}); m_flags = m_flags & ~mk;
      end else if (op == 8) begin
        m_lim = 8'($urandom % 5);
        wr(8'h0C, {8'd0, m_lim, 16'd0});
      end else begin
        m_en = 2'($urandom);
        wr(8'h04, {30'd0, m_en});
      end
      check_state("R2 R4 R7 R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule